// File: doc/BRIEF.md
# One-Time-Enable Watchdog with Reset Pulse Output

This block is a recovery watchdog for an 8-bit microcontroller. It sits on the simple peripheral register bus as a single write-only control location at address 0xA6. After any reset it is idle and does not count. Software turns it on by writing a two-byte key, 0x1E followed directly by 0xE1, to that location. From then on, a 14-bit counter advances once per machine cycle, and software can never turn the watchdog off again.

To stop the counter from overflowing, software writes the same key pair again. Each such write clears the counter to zero. If software fails to do this and the counter reaches 16383, the watchdog does three things:
- it clears its own enable, counter and key-detector state;
- it raises a reset output for a fixed number of oscillator clocks;
- it sets that number from the clock-mode input: 98 clocks in 6-clock mode and 196 in 12-clock mode.

The reset output pulse always completes, even when the system reset input goes high while it is running. This allows the pulse to be looped back into the chip's reset network.

Top module: `wdg_guard`

## Requirements
- R1: After `rst`, the watchdog is disarmed. While it stays disarmed, no number of `mc_tick` cycles makes `rst_out` go high.
- R2: A write of 0x1E to address 0xA6 followed by a write of 0xE1 to address 0xA6 arms the watchdog. The 0xE1 must be the next write to 0xA6. Writes to other addresses in between have no effect on this.
- R3: A write of 0xE1 to 0xA6 with no 0x1E before it is ignored. Any value other than 0xE1 written to 0xA6 after 0x1E cancels the pending key. A later 0xE1 then does not arm the watchdog.
- R4: While armed, the counter advances by one on each clock cycle in which `mc_tick` is 1. Cycles in which `mc_tick` is 0 do not advance it.
- R5: `rst_out` goes high in the cycle after the clock edge on which the 16383rd counted tick since arming or the last service is taken.
- R6: Writing the key pair while armed clears the counter. The next overflow comes 16383 counted ticks after that service.
- R7: No write value can disarm the watchdog. Only `rst` or an overflow does.
- R8: The pulse on `rst_out` lasts 98 clock cycles if `fast_mode` is 1 in the overflow cycle, and 196 clock cycles if it is 0.
- R9: An overflow disarms the watchdog and clears its counter and key state. The pulse runs to full length even if `rst` is asserted during it.
- R10: `bus_rdata` always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous system reset, active high |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| fast_mode | input | 1 | 1 = 6-clock mode, 0 = 12-clock mode |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data, always zero |
| rst_out | output | 1 | Reset pulse output, active high |

## Verification
The bench tries to arm the watchdog with keys that are split by a wrong value, and with a lone 0xE1. A detector that does not return to idle would arm on these and fire a pulse where none is due. It interleaves writes to other addresses, which a detector that decodes too loosely would treat as breaks in the key. It counts the exact tick on which `rst_out` rises and the exact pulse length in both modes, which catches off-by-one limits and swapped mode lengths. It also asserts `rst` in the middle of a pulse and writes junk to the control address while armed, which exposes a pulse that is cut short or an enable that software can clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_OPEN  = 1'b1
  } key_state_t;

  // Next state of the key detector for one bus cycle.
  function automatic key_state_t key_step(input key_state_t cur,
                                          input logic hit,
                                          input logic is_first,
                                          input logic is_second);
    key_state_t nxt;
    nxt = cur;
    if (hit) begin
      if (cur == KEY_OPEN && is_second) nxt = KEY_IDLE;
      else if (is_first)                nxt = KEY_OPEN;
      else                              nxt = KEY_IDLE;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
  import wdg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_done,
  output key_state_t        state_q
);

  logic is_first;
  logic is_second;

  assign is_first  = (wdata == KEY_FIRST);
  assign is_second = (wdata == KEY_SECOND);
  assign key_done  = hit && is_second && (state_q == KEY_OPEN);

  always_ff @(posedge clk) begin
    if (clr) state_q <= KEY_IDLE;
    else     state_q <= key_step(state_q, hit, is_first, is_second);
  end

endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}};

  // True when one more step lands on the limit value.
  function automatic logic one_short(input logic [CNT_W-1:0] v);
    return (v == LIMIT - 1'b1);
  endfunction

  assign at_last = one_short(cnt_q);

  always_ff @(posedge clk) begin
    if (clr || restart) cnt_q <= '0;
    else if (advance)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdg_reset_pulse.sv
module wdg_reset_pulse #(
  parameter int PULSE_FAST = 98,
  parameter int PULSE_SLOW = 196
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic fast_mode,
  output logic pulse
);

  localparam int PW = $clog2(PULSE_SLOW + 1);

  function automatic logic [PW-1:0] span(input logic fast);
    return fast ? PW'(PULSE_FAST) : PW'(PULSE_SLOW);
  endfunction

  logic [PW-1:0] left_q;

  // A running pulse ignores rst; rst only clears an idle counter.
  always_ff @(posedge clk) begin
    if (fire)              left_q <= span(fast_mode);
    else if (left_q != '0) left_q <= left_q - 1'b1;
    else if (rst)          left_q <= '0;
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1,
  parameter int PULSE_FAST = 98,
  parameter int PULSE_SLOW = 196
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_tick,
  input  logic              fast_mode,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_out
);

  logic             ctrl_hit;
  logic             svc_evt;
  logic             ovf_evt;
  logic             wipe;
  logic             armed_q;
  logic             cnt_last;
  logic [CNT_W-1:0] cnt_q;
  key_state_t       key_q;

  assign ctrl_hit  = bus_we && (bus_addr == CTRL_ADDR);
  assign ovf_evt   = !rst && armed_q && mc_tick && cnt_last && !svc_evt;
  assign wipe      = rst || ovf_evt;
  assign bus_rdata = '0;

  wdg_unlock #(
    .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_unlock (
    .clk(clk), .clr(wipe), .hit(ctrl_hit), .wdata(bus_wdata),
    .key_done(svc_evt), .state_q(key_q)
  );

  wdg_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .clr(wipe), .restart(svc_evt),
    .advance(armed_q && mc_tick),
    .cnt_q(cnt_q), .at_last(cnt_last)
  );

  wdg_reset_pulse #(.PULSE_FAST(PULSE_FAST), .PULSE_SLOW(PULSE_SLOW)) u_pulse (
    .clk(clk), .rst(rst), .fire(ovf_evt), .fast_mode(fast_mode),
    .pulse(rst_out)
  );

  // Sticky enable: set by a completed key, cleared only by reset or overflow.
  always_ff @(posedge clk) begin
    if (wipe)         armed_q <= 1'b0;
    else if (svc_evt) armed_q <= 1'b1;
  end

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_tick,
  input logic             rst_out,
  input logic             armed_q,
  input logic             svc_evt,
  input logic             ovf_evt,
  input logic [CNT_W-1:0] cnt_q
);

  // R1
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> cnt_q == '0);

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q && mc_tick && !svc_evt && !ovf_evt |=> cnt_q == $past(cnt_q) + 1'b1);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mc_tick && !svc_evt |=> $stable(cnt_q));

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> rst_out);

  // R6
  service_chk: assert property (@(posedge clk) disable iff (rst)
    svc_evt |=> armed_q && cnt_q == '0);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q && !ovf_evt |=> armed_q);

  // R9
  ovf_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> !armed_q && cnt_q == '0);

endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mc_tick(mc_tick), .rst_out(rst_out),
  .armed_q(armed_q), .svc_evt(svc_evt), .ovf_evt(ovf_evt), .cnt_q(cnt_q)
);

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_tick = 1'b0;
  logic       fast_mode = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rst_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string req = "R1";

  // reference model state
  int  m_arm = 0;
  int  m_cnt = 0;
  int  m_key = 0;
  int  m_left = 0;

  always #2.5 clk = ~clk;

  wdg_guard u_dut (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .fast_mode(fast_mode),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_out(rst_out)
  );

  always @(posedge clk) begin
    bit svc;
    bit ovf;
    cycles++;
    svc = bus_we && bus_addr == 8'hA6 && bus_wdata == 8'hE1 && m_key == 1;
    ovf = !rst && m_arm == 1 && mc_tick && !svc && m_cnt == 16382;
    if (ovf)             m_left = fast_mode ? 98 : 196;
    else if (m_left > 0) m_left--;
    if (rst || ovf) begin
      m_arm = 0; m_cnt = 0; m_key = 0;
    end else begin
      if (svc) begin m_arm = 1; m_cnt = 0; end
      else if (m_arm == 1 && mc_tick) m_cnt++;
      if (bus_we && bus_addr == 8'hA6)
        m_key = (!svc && bus_wdata == 8'h1E) ? 1 : 0;
    end
  end

  task automatic check(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", r, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(req, int'(rst_out), (m_left > 0) ? 1 : 0);
    check("R10", int'(bus_rdata), 0);
  endtask

  task automatic idle(input int n, input bit tk);
    mc_tick = tk;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    mc_tick = 1'b0;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  // Tick (duty 1 of every 'per' cycles) until rst_out is seen; return tick count.
  task automatic run_to_pulse(input int per, output int ticks);
    int c = 0;
    ticks = 0;
    while (!rst_out && ticks < 20000) begin
      mc_tick = (c % per == 0);
      if (mc_tick) ticks++;
      c++;
      step();
    end
    mc_tick = 1'b0;
  endtask

  task automatic measure_pulse(output int len);
    len = 0;
    while (rst_out && len < 400) begin
      len++;
      step();
    end
  endtask

  task automatic no_pulse_seen(input string r, input int n);
    int hi = 0;
    mc_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      if (rst_out) hi++;
    end
    mc_tick = 1'b0;
    check(r, hi, 0);
  endtask

  initial begin
    wait (cycles >= 199000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=finish", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t;
    int len;
    rst = 1'b1;
    req = "R1";
    idle(300, 1'b1);
    check("R1 reset", int'(rst_out), 0);
    check("R10 reset", int'(bus_rdata), 0);
    rst = 1'b0;

    // R3: lone confirm byte, then long ticking: must stay quiet (also R1)
    req = "R3";
    wr(8'hA6, 8'hE1);
    no_pulse_seen("R3 lone E1", 17000);

    // R3: key broken by a different value at the control address
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    wr(8'hA6, 8'hE1);
    no_pulse_seen("R3 broken key", 17000);

    // R2, R5, R8: arm with foreign writes in between, overflow in fast mode
    req = "R2";
    wr(8'hA6, 8'h1E);
    wr(8'h10, 8'h33);
    wr(8'hA7, 8'h00);
    wr(8'hA6, 8'hE1);
    fast_mode = 1'b1;
    run_to_pulse(1, t);
    check("R5 ticks to overflow", t, 16383);
    check("R2 armed by split key", int'(rst_out), 1);
    req = "R8";
    measure_pulse(len);
    check("R8 fast pulse length", len, 98);

    // R9: after overflow the watchdog is disarmed again
    req = "R9";
    no_pulse_seen("R9 disarmed after overflow", 16500);

    // R6, R7: service three times, try junk writes, then slow-mode overflow
    req = "R6";
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    for (int k = 0; k < 3; k++) begin
      idle(10000, 1'b1);
      wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    end
    check("R6 no pulse while serviced", int'(rst_out), 0);
    req = "R7";
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00);
    fast_mode = 1'b0;
    run_to_pulse(1, t);
    check("R6 R7 ticks after last service", t, 16383);

    // R8, R9: slow pulse, system reset asserted midway does not shorten it
    req = "R9";
    len = 0;
    for (int i = 0; i < 50; i++) begin
      if (rst_out) len++;
      step();
    end
    rst = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (rst_out) len++;
      step();
    end
    rst = 1'b0;
    begin
      int rest;
      measure_pulse(rest);
      len += rest;
    end
    check("R8 R9 slow pulse length with rst", len, 196);

    // R4: tick only every other cycle; count still 16383 ticks
    req = "R4";
    fast_mode = 1'b1;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    run_to_pulse(2, t);
    check("R4 gated ticks to overflow", t, 16383);
    measure_pulse(len);
    check("R8 fast pulse after gated run", len, 98);

    idle(10, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule